// File: doc/BRIEF.md
# Embedded Core Control Register

This block is one byte-wide control register that a host writes to manage an embedded microcontroller core and its timing helper unit. From five register bits it drives a held software reset to the bus-interface logic, a held reset to the core and the timing helper, a stall of the core's ready line that also opens direct host access to the local memory bus, a block on power-down entry, and a sticky host interrupt flag.

The wait bit has two jobs. It stalls the core, and it selects which source may set the interrupt flag: the firmware-raised bit while the core runs, or the timing helper's interrupt while the core is stalled. The software-reset bit clears every other bit of the register while it stays at 1, but it does not clear itself. A separate card-level configuration reset clears the lower control bits and also leaves the software-reset bit alone.

Top module: `core_ctl_reg`

## Requirements
- R1: After `rst_n` is released and the synchronizer has run, `rd_data` reads 0x00, `core_rdy` is 1 and every other output is 0. Register bits change only on a host write or one of the reset mechanisms listed below.
- R2: Bit 7 (software reset) is written on every host write and drives `biu_rst`. While it is 1, bits 6 to 3 are held at 0 from the next cycle on, host writes to them are ignored, and interrupt events do not set bit 3.
- R3: Bit 6 (core reset) drives `core_rst`, `tmr_rst`, `flash_wait_force` and `sram_wait_force` for as long as it stays 1. While it is 1, `direct_acc` is 1.
- R4: Bit 4 (core wait) drives `core_rdy` to 0 and `direct_acc` to 1 while it is 1. When it returns to 0, `core_rdy` is 1 again and direct access ends unless bit 6 is set.
- R5: The interrupt set event is `fw_irq` while bit 4 is 0 and `tmr_irq` while bit 4 is 1. The source that is not selected has no effect on bit 3.
- R6: Bit 3 (interrupt flag) becomes 1 the cycle after a set event and stays 1 until the host writes a byte with bit 3 = 1. Writing 0 to bit 3 leaves it unchanged. `host_irq` equals bit 3.
- R7: If a set event and a host write-1 clear of bit 3 happen in the same cycle, bit 3 is 1 afterwards.
- R8: `pwr_down` becomes 1 one cycle after `pd_req` is 1 while bit 5 (power-down disable) is 0. With bit 5 at 1 it stays 0. If bit 5 rises while `pwr_down` is 1, `pwr_down` falls within the next clock.
- R9: Bits 2 to 0 always read as 0, and writes to them have no effect.
- R10: A one-cycle pulse on `cfg_rst` clears bits 6 to 3 at the next edge and leaves bit 7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cfg_rst | input | 1 | Card-level configuration reset pulse |
| wr_en | input | 1 | Host write strobe for the register |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Register read value |
| fw_irq | input | 1 | Firmware-raised interrupt request |
| tmr_irq | input | 1 | Timing helper unit interrupt request |
| pd_req | input | 1 | Power-down request |
| biu_rst | output | 1 | Held reset for the bus-interface logic |
| core_rst | output | 1 | Held reset for the embedded core |
| tmr_rst | output | 1 | Held reset for the timing helper unit |
| flash_wait_force | output | 1 | Forces the flash wait-state field to its default |
| sram_wait_force | output | 1 | Forces the SRAM wait-state field to its default |
| core_rdy | output | 1 | Ready line to the embedded core |
| direct_acc | output | 1 | Host cycles go straight to the local memory bus |
| pwr_down | output | 1 | Power-down state |
| host_irq | output | 1 | Interrupt to the host |

## Verification
The assertions assume that `wr_en`, `wr_data`, `cfg_rst`, both interrupt sources and `pd_req` are synchronous to `clk` and free of X after reset. They also assume that `cfg_rst` is a level the block samples at each edge and not an asynchronous signal. The stimulus meets this by changing every input one nanosecond after a rising edge. It holds `rst_n` low across several edges before the first release, so no property sees a cycle from before reset.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned BIT_SWR = 7;
  localparam int unsigned BIT_CRS = 6;
  localparam int unsigned BIT_NPD = 5;
  localparam int unsigned BIT_WT  = 4;
  localparam int unsigned BIT_FLG = 3;

  typedef struct packed {
    logic swr;
    logic crs;
    logic npd;
    logic wt;
  } ctl_t;
endpackage

// File: rtl/cc_rst_sync.sv
module cc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign arst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cc_ctl_bits.sv
module cc_ctl_bits
  import cc_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cfg_rst,
  output ctl_t             ctl_q
);
  ctl_t ctl_d;
  logic swr_en;
  logic low_en;
  logic low_zero;
  logic unused_wr;

  assign unused_wr = ^{wr_data[BIT_FLG:0]};

  always_comb begin
    swr_en   = wr_en;
    low_zero = ctl_q.swr | cfg_rst;
    low_en   = wr_en | low_zero;
    ctl_d    = ctl_q;
    if (swr_en) ctl_d.swr = wr_data[BIT_SWR];
    if (low_en) begin
      if (low_zero) begin
        ctl_d.crs = 1'b0;
        ctl_d.npd = 1'b0;
        ctl_d.wt  = 1'b0;
      end else begin
        ctl_d.crs = wr_data[BIT_CRS];
        ctl_d.npd = wr_data[BIT_NPD];
        ctl_d.wt  = wr_data[BIT_WT];
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctl_q <= '0;
    end else begin
      if (swr_en) ctl_q.swr <= ctl_d.swr;
      if (low_en) begin
        ctl_q.crs <= ctl_d.crs;
        ctl_q.npd <= ctl_d.npd;
        ctl_q.wt  <= ctl_d.wt;
      end
    end
  end

  // R2: a pending software reset empties the lower control bits
  assert_swr_clears_R2: assert property (@(posedge clk) disable iff (!arst_n)
    ctl_q.swr |=> (!ctl_q.crs && !ctl_q.npd && !ctl_q.wt));

  // R10: configuration reset leaves the software-reset bit alone
  assert_cfg_keeps_swr_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (cfg_rst && !wr_en) |=> (ctl_q.swr == $past(ctl_q.swr)));

  // R10: configuration reset clears the lower control bits
  assert_cfg_clears_R10: assert property (@(posedge clk) disable iff (!arst_n)
    cfg_rst |=> (!ctl_q.crs && !ctl_q.npd && !ctl_q.wt));

  // R1: no write and no reset source means no change
  assert_hold_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (!wr_en && !cfg_rst && !ctl_q.swr) |=> $stable(ctl_q));
endmodule

// File: rtl/cc_irq_flag.sv
module cc_irq_flag (
  input  logic clk,
  input  logic arst_n,
  input  logic sel_tmr,
  input  logic fw_irq,
  input  logic tmr_irq,
  input  logic host_clr,
  input  logic force_zero,
  output logic flag_q
);
  logic set_ev;
  logic flag_d;
  logic flag_en;

  always_comb begin
    set_ev  = sel_tmr ? tmr_irq : fw_irq;
    flag_en = force_zero | set_ev | host_clr;
    if (force_zero)    flag_d = 1'b0;
    else if (set_ev)   flag_d = 1'b1;
    else if (host_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  // R7: a set event beats a same-cycle host clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (((sel_tmr && tmr_irq) || (!sel_tmr && fw_irq)) && !force_zero) |=> flag_q);

  // R6: the flag holds until a clear
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (flag_q && !host_clr && !force_zero) |=> flag_q);

  // R6: a host clear with no event drops the flag
  assert_clear_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (host_clr && !(sel_tmr ? tmr_irq : fw_irq)) |=> !flag_q);

  // R5: the source that is not selected cannot raise the flag
  assert_unselected_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (!flag_q && (sel_tmr ? !tmr_irq : !fw_irq)) |=> !flag_q);
endmodule

// File: rtl/cc_pd_ctl.sv
module cc_pd_ctl (
  input  logic clk,
  input  logic arst_n,
  input  logic pd_req,
  input  logic pd_block,
  output logic pd_q
);
  logic pd_d;

  always_comb pd_d = pd_req & ~pd_block;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pd_q <= 1'b0;
    else         pd_q <= pd_d;
  end

  // R8: a set disable bit forces an exit at the next edge
  assert_pd_exit_R8: assert property (@(posedge clk) disable iff (!arst_n)
    pd_block |=> !pd_q);

  // R8: an allowed request enters power-down
  assert_pd_enter_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (pd_req && !pd_block) |=> pd_q);
endmodule

// File: rtl/core_ctl_reg.sv
module core_ctl_reg
  import cc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             fw_irq,
  input  logic             tmr_irq,
  input  logic             pd_req,
  output logic             biu_rst,
  output logic             core_rst,
  output logic             tmr_rst,
  output logic             flash_wait_force,
  output logic             sram_wait_force,
  output logic             core_rdy,
  output logic             direct_acc,
  output logic             pwr_down,
  output logic             host_irq
);
  localparam int unsigned LOW_W = BIT_FLG;

  logic arst_n;
  ctl_t ctl_q;
  logic flag_q;
  logic host_clr;
  logic flag_zero;

  cc_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .arst_n (arst_n)
  );

  cc_ctl_bits i_bits (
    .clk     (clk),
    .arst_n  (arst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_rst (cfg_rst),
    .ctl_q   (ctl_q)
  );

  assign host_clr  = wr_en & wr_data[BIT_FLG];
  assign flag_zero = ctl_q.swr | cfg_rst;

  cc_irq_flag i_flag (
    .clk        (clk),
    .arst_n     (arst_n),
    .sel_tmr    (ctl_q.wt),
    .fw_irq     (fw_irq),
    .tmr_irq    (tmr_irq),
    .host_clr   (host_clr),
    .force_zero (flag_zero),
    .flag_q     (flag_q)
  );

  cc_pd_ctl i_pd (
    .clk      (clk),
    .arst_n   (arst_n),
    .pd_req   (pd_req),
    .pd_block (ctl_q.npd),
    .pd_q     (pwr_down)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_SWR] = ctl_q.swr;
    rd_data[BIT_CRS] = ctl_q.crs;
    rd_data[BIT_NPD] = ctl_q.npd;
    rd_data[BIT_WT]  = ctl_q.wt;
    rd_data[BIT_FLG] = flag_q;
    rd_data[LOW_W-1:0] = '0;
  end

  assign biu_rst          = ctl_q.swr;
  assign core_rst         = ctl_q.crs;
  assign tmr_rst          = ctl_q.crs;
  assign flash_wait_force = ctl_q.crs;
  assign sram_wait_force  = ctl_q.crs;
  assign core_rdy         = ~ctl_q.wt;
  assign direct_acc       = ctl_q.wt | ctl_q.crs;
  assign host_irq         = flag_q;

  // R5: with the core stalled, a timing-helper interrupt reaches the host
  assert_tmr_source_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (!ctl_q.swr && !cfg_rst && ctl_q.wt && tmr_irq) |=> host_irq);

  // R5: with the core running, a firmware interrupt reaches the host
  assert_fw_source_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (!ctl_q.swr && !cfg_rst && !ctl_q.wt && fw_irq) |=> host_irq);

  // R2: software reset keeps the interrupt line quiet
  assert_swr_quiet_R2: assert property (@(posedge clk) disable iff (!arst_n)
    biu_rst |=> !host_irq);
endmodule

// File: tb/test_core_ctl_reg.sv
module test_core_ctl_reg;
  logic       clk;
  logic       rst_n;
  logic       cfg_rst;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       fw_irq, tmr_irq, pd_req;
  logic       biu_rst, core_rst, tmr_rst, flash_wait_force, sram_wait_force;
  logic       core_rdy, direct_acc, pwr_down, host_irq;

  core_ctl_reg i_core_ctl_reg (
    .clk(clk), .rst_n(rst_n), .cfg_rst(cfg_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .fw_irq(fw_irq), .tmr_irq(tmr_irq),
    .pd_req(pd_req), .biu_rst(biu_rst), .core_rst(core_rst), .tmr_rst(tmr_rst),
    .flash_wait_force(flash_wait_force), .sram_wait_force(sram_wait_force),
    .core_rdy(core_rdy), .direct_acc(direct_acc), .pwr_down(pwr_down),
    .host_irq(host_irq)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string phase = "R1";

  // behavioural reference state
  int sync_cnt = 0;
  bit m_swr, m_crs, m_npd, m_wt, m_flg, m_pd;
  bit t_zero, t_set, t_flg, t_pd;

  initial clk = 0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cmp_on = 1;
    if (!rst_n || sync_cnt < 2) begin
      if (!rst_n) sync_cnt = 0; else sync_cnt = sync_cnt + 1;
      m_swr = 0; m_crs = 0; m_npd = 0; m_wt = 0; m_flg = 0; m_pd = 0;
    end else begin
      t_zero = m_swr || cfg_rst;
      t_set  = m_wt ? tmr_irq : fw_irq;
      if (t_zero)                     t_flg = 0;
      else if (t_set)                 t_flg = 1;
      else if (wr_en && wr_data[3])   t_flg = 0;
      else                            t_flg = m_flg;
      t_pd = pd_req && !m_npd;
      if (t_zero) begin
        m_crs = 0; m_npd = 0; m_wt = 0;
      end else if (wr_en) begin
        m_crs = wr_data[6]; m_npd = wr_data[5]; m_wt = wr_data[4];
      end
      if (wr_en) m_swr = wr_data[7];
      m_flg = t_flg;
      m_pd  = t_pd;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at cycle %0d",
               tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(phase, "rd_data[7:3]", {3'b0, rd_data[7:3]},
          {3'b0, m_swr, m_crs, m_npd, m_wt, m_flg});
      chk("R9", "rd_data[2:0]", {5'b0, rd_data[2:0]}, 8'h00);
      chk("R2", "biu_rst", {7'b0, biu_rst}, {7'b0, m_swr});
      chk("R3", "core_rst", {7'b0, core_rst}, {7'b0, m_crs});
      chk("R3", "tmr_rst", {7'b0, tmr_rst}, {7'b0, m_crs});
      chk("R3", "flash_wait_force", {7'b0, flash_wait_force}, {7'b0, m_crs});
      chk("R3", "sram_wait_force", {7'b0, sram_wait_force}, {7'b0, m_crs});
      chk("R4", "core_rdy", {7'b0, core_rdy}, {7'b0, !m_wt});
      chk("R4", "direct_acc", {7'b0, direct_acc}, {7'b0, m_wt || m_crs});
      chk("R8", "pwr_down", {7'b0, pwr_down}, {7'b0, m_pd});
      chk("R6", "host_irq", {7'b0, host_irq}, {7'b0, m_flg});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; wr_data = 8'h00;
  endtask

  initial begin
    rst_n = 0; cfg_rst = 0; wr_en = 0; wr_data = 0;
    fw_irq = 0; tmr_irq = 0; pd_req = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    // R1: reset state compared cycle by cycle
    phase = "R1"; idle(3);
    // R9: low bits write-ignored
    phase = "R9"; wr(8'h07); idle(2);
    // R4: wait bit stalls core
    phase = "R4"; wr(8'h10); idle(2); wr(8'h00); idle(2);
    // R3: core reset held
    phase = "R3"; wr(8'h40); idle(3); wr(8'h00); idle(2);
    // R5: source selection
    phase = "R5";
    fw_irq = 1; idle(1); fw_irq = 0; idle(2);
    wr(8'h08); idle(1);
    wr(8'h10);
    fw_irq = 1; idle(3); fw_irq = 0;
    tmr_irq = 1; idle(1); tmr_irq = 0; idle(2);
    // R6: write 0 keeps flag, write 1 clears
    phase = "R6"; wr(8'h10); idle(2); wr(8'h18); idle(2);
    // R7: set beats clear
    phase = "R7";
    tmr_irq = 1; wr(8'h18); tmr_irq = 0; idle(2); wr(8'h08); idle(2);
    // R8: power-down entry, blocked, exit
    phase = "R8";
    pd_req = 1; idle(3); wr(8'h20); idle(3); wr(8'h00); idle(3);
    pd_req = 0; idle(2);
    // R2: software reset clears everything but itself
    phase = "R2";
    fw_irq = 1; idle(1); fw_irq = 0;
    wr(8'h70); idle(1); wr(8'hF0); idle(2); wr(8'hF8);
    tmr_irq = 1; fw_irq = 1; idle(3); tmr_irq = 0; fw_irq = 0;
    wr(8'h00); idle(2);
    // R10: configuration reset
    phase = "R10";
    wr(8'h70); fw_irq = 1; idle(1); fw_irq = 0;
    cfg_rst = 1; idle(1); cfg_rst = 0; idle(2);
    wr(8'h80); cfg_rst = 1; idle(1); cfg_rst = 0; idle(2); wr(8'h00); idle(2);
    // mixed traffic
    phase = "R5";
    for (int k = 0; k < 600; k++) begin
      wr_en   = (($urandom % 4) == 0);
      wr_data = 8'($urandom);
      if (wr_data[7] && ($urandom % 2 == 0)) wr_data[7] = 1'b0;
      cfg_rst = (($urandom % 20) == 0);
      fw_irq  = (($urandom % 6) == 0);
      tmr_irq = (($urandom % 6) == 0);
      pd_req  = (($urandom % 2) == 0);
      idle(1);
    end
    wr_en = 0; cfg_rst = 0; fw_irq = 0; tmr_irq = 0; pd_req = 0;
    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule